// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a motor drive against a stalled or runaway rotor. While the motor is commanded to run, it measures how long the speed loop reports an unlocked condition. The measurement uses a slow tick that a prescaler derives from the system clock. When the unlocked time reaches a programmable limit, the block latches a shutdown that switches off the low-side drive stage. Only a stop command or a power-on reset releases that latch.

The same tick timebase also produces the initial reset for the speed-control logic after power-up. During braking done by changing the reference frequency, the timer pauses. An optional mode treats a reference clock that has gone missing as a fault in its own right. A protection-enable input removes the timeout but leaves the power-up reset pulse in place.

Top module: `stall_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `lowside_off` is 0 and `speed_rst` is 1.
- R2: `speed_rst` stays at 1 until POR_TICKS ticks have elapsed after reset. It then falls and never rises again before the next reset. While `speed_rst` is 1, no shutdown can be latched.
- R3: A tick occurs once every PRESCALE clock cycles. The first tick falls on the PRESCALE-th cycle after reset. The block is armed when `run`=1, `prot_en`=1, `clk_brake`=0 and `speed_rst`=0. Each tick taken while armed with `unlocked`=1 adds one to the stall count. On the tick that brings the count to `limit`, `lowside_off` rises one clock later. A `limit` of 0 acts as 1.
- R4: A cycle with `unlocked`=0 clears the stall count to zero. Lock lost and regained before the limit therefore never trips.
- R5: Once `lowside_off` is 1, it stays 1 while `run`=1, whatever the values of `unlocked`, `clk_brake` and `prot_en`. It falls one cycle after `run` is sampled 0.
- R6: While `clk_brake`=1, the stall count holds its value. Counting resumes from that value when braking ends.
- R7: With `prot_en`=0, the stall count is cleared and no shutdown is latched. `speed_rst` behaves as in R2.
- R8: With `miss_mode`=1, a second count adds one on each armed tick and clears on any cycle where `ref_edge`=1. If MISS_TICKS armed ticks pass without a `ref_edge`, the shutdown is latched. This happens even while locked. With `miss_mode`=0, a missing reference never trips the block.
- R9: `run`=0 clears both counts. Unlocked time from before a stop does not carry over into the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| run | input | 1 | 1 = start command, 0 = stop |
| unlocked | input | 1 | 1 while the speed loop is out of lock |
| clk_brake | input | 1 | 1 while braking by reference frequency change |
| ref_edge | input | 1 | One-cycle pulse per reference clock edge |
| prot_en | input | 1 | 1 enables the stall and missing-clock timeouts |
| miss_mode | input | 1 | 1 treats a missing reference clock as a fault |
| limit | input | LIMIT_W | Stall timeout in ticks |
| lowside_off | output | 1 | Latched shutdown of the low-side drive |
| speed_rst | output | 1 | Initial reset for the speed-control logic |

## Verification
The bench goes after several corner cases:
- A brief return to lock just short of the limit. A design that only pauses the count would trip too early here.
- A long braking window partway through a count. A design that clears the count would trip too late, and one that keeps counting would trip while braking.
- Lock regained after a trip. A design with a self-clearing latch would release the drive without a stop command.
- A zero limit, a disabled timeout, and a reference clock that stops while the loop is still locked.

A stop between two partial unlocked periods must keep them from adding up. A timer that runs during the power-up reset would trip before the speed logic is even released.

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter int PRESCALE   = 50000,
  parameter int LIMIT_W    = 10,
  parameter int POR_TICKS  = 16,
  parameter int MISS_TICKS = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               unlocked,
  input  logic               clk_brake,
  input  logic               ref_edge,
  input  logic               prot_en,
  input  logic               miss_mode,
  input  logic [LIMIT_W-1:0] limit,
  output logic               lowside_off,
  output logic               speed_rst
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int POR_W  = $clog2(POR_TICKS + 1);
  localparam int MISS_W = $clog2(MISS_TICKS + 1);

  logic [PRE_W-1:0]   pre;
  logic [POR_W-1:0]   por;
  logic [LIMIT_W-1:0] stall;
  logic [MISS_W-1:0]  miss;
  logic               tick, arm, stall_hit, miss_hit;

  assign tick      = (pre == PRE_W'(PRESCALE - 1));
  assign speed_rst = (por != POR_W'(POR_TICKS));
  assign arm       = run & prot_en & ~clk_brake & ~speed_rst;
  assign stall_hit = arm & tick & unlocked &
                     ({1'b0, stall} + 1'b1 >= {1'b0, limit});
  assign miss_hit  = arm & tick & miss_mode & ~ref_edge &
                     ({1'b0, miss} + 1'b1 >= (MISS_W+1)'(MISS_TICKS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0;
      por <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && speed_rst) por <= por + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stall <= '0;
    else if (!run || !prot_en || !unlocked) stall <= '0;
    else if (arm && tick && stall != '1) stall <= stall + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) miss <= '0;
    else if (!run || ref_edge) miss <= '0;
    else if (arm && tick && miss != MISS_W'(MISS_TICKS)) miss <= miss + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowside_off <= 1'b0;
    else if (!run) lowside_off <= 1'b0;
    else if (stall_hit || miss_hit) lowside_off <= 1'b1;

  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !lowside_off);
  // R5
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lowside_off) |=> lowside_off);
  // R2
  por_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_rst |=> !speed_rst);
  // R6
  no_trip_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowside_off) |-> $past(run && prot_en && !clk_brake));
  // R2
  no_trip_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowside_off) |-> $past(!speed_rst));
endmodule

// File: tb/stall_guard_test.sv
module stall_guard_test;
  localparam int P = 4, LW = 6, PT = 3, MT = 12;
  logic clk = 0, rst_n = 0, run = 0, unl = 0, brk = 0, edg = 0, en = 1, mm = 0;
  logic [LW-1:0] lim = 10;
  logic lowside_off, speed_rst;
  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  int m_pre, m_por, m_acc, m_miss, m_lat;

  always #5 clk = ~clk;

  stall_guard #(.PRESCALE(P), .LIMIT_W(LW), .POR_TICKS(PT), .MISS_TICKS(MT)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .unlocked(unl), .clk_brake(brk),
    .ref_edge(edg), .prot_en(en), .miss_mode(mm), .limit(lim),
    .lowside_off(lowside_off), .speed_rst(speed_rst));

  always @(posedge clk) begin
    bit tk, busy, armed;
    if (!rst_n) begin
      m_pre = 0; m_por = 0; m_acc = 0; m_miss = 0; m_lat = 0;
    end else begin
      tk = (m_pre == P - 1);
      busy = (m_por < PT);
      armed = run && en && !brk && !busy;
      if (!run) m_lat = 0;
      else if (armed && tk && unl && (m_acc + 1 >= int'(lim))) m_lat = 1;
      else if (armed && tk && mm && !edg && (m_miss + 1 >= MT)) m_lat = 1;
      if (!run || !en || !unl) m_acc = 0;
      else if (armed && tk && m_acc < 63) m_acc++;
      if (!run || edg) m_miss = 0;
      else if (armed && tk && m_miss < MT) m_miss++;
      if (tk && busy) m_por++;
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  task automatic check(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({tag, " lowside_off"}, lowside_off, m_lat);
      check({tag, " speed_rst"}, speed_rst, (m_por < PT) ? 1 : 0);
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      edg = 1; waitc(1); edg = 0; waitc(7);
    end
  endtask

  initial begin
    waitc(3);
    check("R1 off in reset", lowside_off, 0);
    check("R1 srst in reset", speed_rst, 1);
    rst_n = 1; waitc(1);
    check("R1 srst after reset", speed_rst, 1);
    tag = "R2"; run = 1; unl = 1; waitc(20);
    check("R2 srst released", speed_rst, 0);
    check("R2 no trip during por", lowside_off, 0);
    tag = "R3"; waitc(45);
    check("R3 stall trips", lowside_off, 1);
    tag = "R5"; unl = 0; brk = 1; en = 0; waitc(30);
    check("R5 latch holds", lowside_off, 1);
    brk = 0; en = 1; run = 0; waitc(2);
    check("R5 stop clears", lowside_off, 0);
    tag = "R4"; run = 1; unl = 1; waitc(24); unl = 0; waitc(2); unl = 1; waitc(30);
    check("R4 lock regain restarts count", lowside_off, 0);
    waitc(20);
    check("R4 later trip", lowside_off, 1);
    run = 0; waitc(2);
    tag = "R6"; run = 1; waitc(20); brk = 1; waitc(60);
    check("R6 no trip while braking", lowside_off, 0);
    brk = 0; waitc(16);
    check("R6 count held not cleared", lowside_off, 0);
    waitc(12);
    check("R6 resumes to trip", lowside_off, 1);
    run = 0; waitc(2);
    tag = "R7"; en = 0; run = 1; waitc(200);
    check("R7 disabled no trip", lowside_off, 0);
    check("R7 srst untouched", speed_rst, 0);
    en = 1; run = 0; waitc(2);
    tag = "R8"; unl = 0; run = 1; mm = 1; edges(14);
    check("R8 edges keep running", lowside_off, 0);
    waitc(56);
    check("R8 missing clock trips", lowside_off, 1);
    run = 0; mm = 0; waitc(2); run = 1; waitc(100);
    check("R8 mode off no trip", lowside_off, 0);
    run = 0; waitc(2);
    tag = "R3"; lim = 0; unl = 1; run = 1; waitc(6);
    check("R3 zero limit trips on first tick", lowside_off, 1);
    run = 0; lim = 10; waitc(2);
    tag = "R9"; run = 1; waitc(32); run = 0; waitc(1); run = 1; waitc(28);
    check("R9 stop clears count", lowside_off, 0);
    waitc(20);
    check("R9 fresh count trips", lowside_off, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule